// File: doc/BRIEF.md
# Asynchronous Host Latch Port

This block lets an external microprocessor reach an 8-bit data latch inside a synchronous design. The host uses three active-low strobes: chip select, read and write. These strobes have no timing relation to the internal clock. Each strobe passes through a multi-flop synchroniser. The block then edge-detects the combined "select plus write" and "select plus read" conditions. Each host access therefore produces exactly one transfer event, counted in whole clock cycles.

The internal side has these controls:
- a mode enable that switches the whole port on or off;
- a load strobe for the outgoing latch;
- a read-acknowledge strobe for the incoming latch;
- a write-one-to-clear input for the interrupt.

It reports four flags: input-buffer-full, output-buffer-full, a sticky overflow and a sticky interrupt. The host side drives the data bus only while a read is in progress. The enable is combinational, so the bus is released as soon as select or read returns high.

Top module: `par_slave_port`

## Requirements
- R1: After a synchronous reset, both latches read zero, and inFull, outFull, overflow, irq and busOe are all 0.
- R2: While modeEn is 1, the first synchronised cycle with csN and wrN both low is a host write. busIn is captured into the incoming latch, and inFull and irq are set. All of this is visible on the ports three clock edges after the strobes fall.
- R3: A select/strobe pair held low for many cycles produces exactly one transfer event. After irq is cleared during the hold, it does not set again before the strobes rise.
- R4: busOe is 1 exactly while modeEn is 1 and csN and rdN are both low, with no clock delay. While busOe is 1, busOut equals the outgoing latch.
- R5: A host read (csN and rdN both low, while modeEn is 1) clears outFull and sets irq three clock edges after the strobes fall.
- R6: A one-cycle pulse on cpuWrOut loads cpuWrData into the outgoing latch and sets outFull on the next edge.
- R7: A one-cycle pulse on cpuRdIn clears inFull on the next edge. cpuRdData always shows the incoming latch.
- R8: A host write that arrives while inFull is 1 sets overflow. overflow stays 1 until reset, and the new data still replaces the incoming latch.
- R9: irq stays 1 until an irqClr pulse. If a new transfer event and irqClr land in the same cycle, irq stays set.
- R10: While modeEn is 0, the strobes change no latch and no flag, and busOe stays 0.
- R11: With csN high, a low pulse on wrN or on rdN alone is not a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| modeEn | input | 1 | Port function enable |
| csN | input | 1 | Host chip select, active low, asynchronous |
| rdN | input | 1 | Host read strobe, active low, asynchronous |
| wrN | input | 1 | Host write strobe, active low, asynchronous |
| busIn | input | 8 | Host data bus, incoming value |
| busOut | output | 8 | Host data bus, outgoing value |
| busOe | output | 1 | Host data bus drive enable |
| cpuWrOut | input | 1 | Internal load pulse for the outgoing latch |
| cpuWrData | input | 8 | Data for the outgoing latch |
| cpuRdIn | input | 1 | Internal read-acknowledge pulse for the incoming latch |
| cpuRdData | output | 8 | Incoming latch contents |
| irqClr | input | 1 | Write-one-to-clear pulse for irq |
| inFull | output | 1 | Incoming latch holds unread host data |
| outFull | output | 1 | Outgoing latch not yet read by the host |
| overflow | output | 1 | Sticky: host write landed on a full incoming latch |
| irq | output | 1 | Sticky transfer interrupt |

## Verification
Random sequences mix host writes and reads of varying hold lengths with internal loads, acknowledges and interrupt clears. All of these are compared against a flag model in the bench. This shows whether set and clear ordering among the flags is right across many interleavings.

Directed cases cover the following, each separating edge detection and gating from plain level decoding:
- long holds with an interrupt clear in mid-strobe;
- writes onto a full latch;
- lone read or write strobes with select high;
- traffic with the mode disabled.

The combinational bus enable is probed inside and just after each read pulse, to confirm it is not registered.

// File: rtl/psp_pkg.sv
package psp_pkg;
  localparam int NUM_STROBES = 3;
  localparam int IDX_CS = 2;
  localparam int IDX_RD = 1;
  localparam int IDX_WR = 0;

  typedef struct packed {
    logic capIn;    // capture host bus into incoming latch
    logic loadOut;  // load internal data into outgoing latch
  } pspStrobes_t;
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
  parameter int STAGES = 2,
  parameter int NUM    = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] rawIn,
  output logic [NUM-1:0] syncOut
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM; gi++) begin : gSync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], rawIn[gi]};
      end
      assign syncOut[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modeEn,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        cpuWrOut,
  input  logic        cpuRdIn,
  input  logic        irqClr,
  output pspStrobes_t strobes,
  output logic        busOe,
  output logic        inFull,
  output logic        outFull,
  output logic        overflow,
  output logic        irq
);
  logic [NUM_STROBES-1:0] rawVec, syncVec;
  logic wrLow, rdLow, wrLowD, rdLowD, wrEvt, rdEvt;

  assign rawVec[IDX_CS] = csN;
  assign rawVec[IDX_RD] = rdN;
  assign rawVec[IDX_WR] = wrN;

  psp_sync #(.STAGES(SYNC_STAGES), .NUM(NUM_STROBES)) uSync (
    .clk(clk), .rst(rst), .rawIn(rawVec), .syncOut(syncVec)
  );

  assign wrLow = modeEn & ~syncVec[IDX_CS] & ~syncVec[IDX_WR];
  assign rdLow = modeEn & ~syncVec[IDX_CS] & ~syncVec[IDX_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrLowD <= 1'b0;
      rdLowD <= 1'b0;
    end else begin
      wrLowD <= wrLow;
      rdLowD <= rdLow;
    end
  end

  assign wrEvt = wrLow & ~wrLowD;
  assign rdEvt = rdLow & ~rdLowD;

  assign strobes.capIn   = wrEvt;
  assign strobes.loadOut = cpuWrOut;

  assign busOe = modeEn & ~csN & ~rdN;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFull   <= 1'b0;
      outFull  <= 1'b0;
      overflow <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wrEvt)        inFull <= 1'b1;
      else if (cpuRdIn) inFull <= 1'b0;

      if (cpuWrOut)     outFull <= 1'b1;
      else if (rdEvt)   outFull <= 1'b0;

      if (wrEvt && inFull) overflow <= 1'b1;

      if (wrEvt || rdEvt) irq <= 1'b1;
      else if (irqClr)    irq <= 1'b0;
    end
  end
endmodule

// File: rtl/psp_datapath.sv
module psp_datapath
  import psp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pspStrobes_t       strobes,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] inLatch,
  output logic [DATA_W-1:0] outLatch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inLatch  <= '0;
      outLatch <= '0;
    end else begin
      if (strobes.capIn)   inLatch  <= busIn;
      if (strobes.loadOut) outLatch <= cpuWrData;
    end
  end
endmodule

// File: rtl/par_slave_port.sv
module par_slave_port
  import psp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeEn,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              cpuWrOut,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdIn,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              irqClr,
  output logic              inFull,
  output logic              outFull,
  output logic              overflow,
  output logic              irq
);
  pspStrobes_t strobes;

  psp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .modeEn(modeEn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .cpuWrOut(cpuWrOut), .cpuRdIn(cpuRdIn), .irqClr(irqClr),
    .strobes(strobes), .busOe(busOe), .inFull(inFull), .outFull(outFull),
    .overflow(overflow), .irq(irq)
  );

  psp_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .busIn(busIn),
    .cpuWrData(cpuWrData), .inLatch(cpuRdData), .outLatch(busOut)
  );
endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              modeEn,
  input logic              csN,
  input logic              rdN,
  input logic              cpuWrOut,
  input logic [DATA_W-1:0] cpuWrData,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic              irqClr,
  input logic              inFull,
  input logic              outFull,
  input logic              overflow,
  input logic              irq
);
  always_comb begin
    if (!rst && !modeEn) AST_NO_DRIVE_OFF: assert (!busOe); // R10
    if (!rst && (csN || rdN)) AST_OE_RELEASE: assert (!busOe); // R4
  end

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    cpuWrOut |=> (outFull && busOut == $past(cpuWrData))); // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqClr) |=> irq); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_FULL_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(inFull) |-> irq); // R2
  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !modeEn |=> !$rose(inFull)); // R10
endmodule

bind par_slave_port psp_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .modeEn(modeEn), .csN(csN), .rdN(rdN),
  .cpuWrOut(cpuWrOut), .cpuWrData(cpuWrData), .busOut(busOut), .busOe(busOe),
  .irqClr(irqClr), .inFull(inFull), .outFull(outFull), .overflow(overflow),
  .irq(irq)
);

// File: tb/tb_par_slave_port.sv
module tb_par_slave_port;
  logic clk = 0, rst = 1, modeEn = 0, csN = 1, rdN = 1, wrN = 1;
  logic [7:0] busIn = 0, cpuWrData = 0;
  logic cpuWrOut = 0, cpuRdIn = 0, irqClr = 0;
  logic [7:0] busOut, cpuRdData;
  logic busOe, inFull, outFull, overflow, irq;
  int checks = 0, errors = 0;
  logic [7:0] mIn = 0, mOut = 0;
  logic mIbf = 0, mObf = 0, mOvf = 0, mIrq = 0;

  always #2 clk = ~clk;

  par_slave_port dut (.*);

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expFlags();
    return {mIbf, mObf, mOvf, mIrq};
  endfunction

  task automatic checkAll(input string req);
    logic [3:0] act = {inFull, outFull, overflow, irq};
    chk(act == expFlags(), {req, " flags"}, act, expFlags());
    chk(cpuRdData == mIn, {req, " inLatch"}, cpuRdData, mIn);
    chk(busOe == 1'b0, {req, " busOe idle"}, busOe, 0);
  endtask

  task automatic hostWrite(input logic [7:0] d, input int hold, input bit useCs);
    @(negedge clk);
    busIn = d; wrN = 0; csN = !useCs;
    repeat (hold) @(negedge clk);
    wrN = 1; csN = 1;
    repeat (4) @(negedge clk);
    if (useCs && modeEn) begin
      if (mIbf) mOvf = 1;
      mIn = d; mIbf = 1; mIrq = 1;
    end
  endtask

  task automatic hostRead(input int hold, input bit useCs, input string req);
    @(negedge clk);
    rdN = 0; csN = !useCs;
    #1;
    chk(busOe == (useCs && modeEn), {req, " oe during read"}, busOe, useCs && modeEn);
    if (busOe) chk(busOut == mOut, {req, " busOut"}, busOut, mOut);
    repeat (hold) @(negedge clk);
    rdN = 1; csN = 1;
    #1;
    chk(busOe == 0, "R4 oe release", busOe, 0);
    repeat (4) @(negedge clk);
    if (useCs && modeEn) begin mObf = 0; mIrq = 1; end
  endtask

  task automatic cpuLoad(input logic [7:0] d);
    @(negedge clk); cpuWrOut = 1; cpuWrData = d;
    @(negedge clk); cpuWrOut = 0;
    mOut = d; mObf = 1;
    chk(outFull == 1, "R6 outFull", outFull, 1);
  endtask

  task automatic cpuAck();
    @(negedge clk); cpuRdIn = 1;
    @(negedge clk); cpuRdIn = 0;
    mIbf = 0;
    chk(inFull == 0, "R7 inFull cleared", inFull, 0);
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClr = 1;
    @(negedge clk); irqClr = 0;
    mIrq = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checkAll("R1");
    chk(busOut == 0, "R1 outLatch", busOut, 0);
    modeEn = 1;

    // R2 basic write, R7 ack
    hostWrite(8'hA5, 2, 1); checkAll("R2");
    cpuAck(); checkAll("R7");
    clearIrq(); checkAll("R9 clear");

    // R3 long hold with clear mid-strobe
    @(negedge clk); busIn = 8'h3C; wrN = 0; csN = 0;
    repeat (6) @(negedge clk);
    irqClr = 1; @(negedge clk); irqClr = 0;
    repeat (6) @(negedge clk);
    chk(irq == 0, "R3 single event", irq, 0);
    chk(inFull == 1 && cpuRdData == 8'h3C, "R3 captured", cpuRdData, 8'h3C);
    wrN = 1; csN = 1; repeat (4) @(negedge clk);
    mIn = 8'h3C; mIbf = 1; mIrq = 0;
    checkAll("R3");

    // R8 overflow
    hostWrite(8'h77, 1, 1); checkAll("R8");
    chk(overflow == 1, "R8 sticky", overflow, 1);
    cpuAck(); checkAll("R8 after ack");

    // R5/R4 read path
    cpuLoad(8'hC3); hostRead(3, 1, "R4"); checkAll("R5");

    // R9 set wins over clear in same cycle
    clearIrq();
    @(negedge clk); busIn = 8'h11; wrN = 0; csN = 0;
    @(negedge clk); @(negedge clk); irqClr = 1;
    @(negedge clk); irqClr = 0; wrN = 1; csN = 1;
    repeat (3) @(negedge clk);
    chk(irq == 1, "R9 set wins", irq, 1);
    if (mIbf) mOvf = 1;
    mIn = 8'h11; mIbf = 1; mIrq = 1;
    checkAll("R9");
    cpuAck(); clearIrq();

    // R11 lone strobes
    hostWrite(8'hEE, 2, 0); checkAll("R11 write");
    hostRead(2, 0, "R11"); checkAll("R11 read");

    // R10 mode off
    modeEn = 0;
    hostWrite(8'h99, 2, 1); checkAll("R10 write");
    cpuLoad(8'h5A);
    hostRead(2, 1, "R10"); checkAll("R10 read");
    modeEn = 1;
    repeat (3) @(negedge clk);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: hostWrite(8'($urandom), $urandom_range(1, 5), 1);
        1: hostRead($urandom_range(1, 5), 1, "R4 rand");
        2: cpuLoad(8'($urandom));
        3: cpuAck();
        4: clearIrq();
        default: hostWrite(8'($urandom), 2, 0);
      endcase
      checkAll("R2 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule